// File: doc/BRIEF.md
# Four-Bit Register and ALU Processor Slice

This block is a small 4-bit datapath slice for control and test work. It holds a sixteen-word scratch memory four bits wide. It also has four 4-bit working registers, named A to D, an instruction decoder, an operand selector and a 4-bit arithmetic and logic unit. There is no program counter and no instruction fetch. A host first fills the memory through a write port. It then presents one 12-bit instruction on every clock.

Each instruction has three fields. The top nibble picks the second operand. The middle nibble is a memory address. The low nibble is the operation. Move operations copy a memory word into one of the four registers. Arithmetic, shift, rotate and logic operations take register A and a selected register, and write the result back into A. A compare sets the carry and shows the difference, but writes no register. The 4-bit result and the carry appear on registered outputs one clock after the instruction is presented.

Top module: `nibble_slice_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, `result`, `carry_out` and all four registers are cleared to zero. Memory contents are not defined by reset.
- R2: When `wr_en` is high at a rising edge, `wr_data` is stored at memory address `wr_addr`.
- R3: Opcodes 10, 11, 12 and 13 copy the memory word at `instr[7:4]` into register A, B, C and D respectively. `result` then shows that word and `carry_out` is 0.
- R4: The second operand comes from the one-hot field `instr[11:8]`, where bit 8 is A, bit 9 is B, bit 10 is C and bit 11 is D. When several bits are set, the lowest set bit wins. When no bit is set, B is used.
- R5: Opcode 0 computes A + operand + `carry_in`. `carry_out` is the carry out of bit 3.
- R6: Opcode 1 computes A + not(operand) + `carry_in`, which is a subtract with the borrow taken as an inverted carry. `carry_out` is the carry out of bit 3, and 0 means a borrow.
- R7: Opcode 2 computes A − operand with the carry-in forced to 1 and shows the difference and the carry. It writes no register.
- R8: Opcode 3 shifts A left and opcode 4 shifts A right. A zero enters the vacated bit and `carry_out` takes the bit shifted out.
- R9: Opcode 5 rotates A left and opcode 6 rotates A right. `carry_out` is a copy of the bit that wrapped around.
- R10: Opcode 7 gives A AND operand, opcode 8 gives A OR operand and opcode 9 gives NOT A. For all three, `carry_out` is 0.
- R11: Every operation with opcode 0 to 9 except opcode 2 writes its 4-bit result into register A.
- R12: Opcodes 14 and 15 change neither `result`, `carry_out` nor any register.
- R13: `result` and `carry_out` change only at the rising edge that captures the instruction.
- R14: A move that reads the same address that is being written in the same cycle receives the word stored before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 12 | Instruction: operand select, memory address, opcode |
| wr_en | input | 1 | Memory write enable |
| wr_addr | input | 4 | Memory write address |
| wr_data | input | 4 | Memory write data |
| carry_in | input | 1 | Carry input for add and subtract |
| result | output | 4 | Registered 4-bit result |
| carry_out | output | 1 | Registered carry output |

## Verification
The memory write port and the instruction path are independent, so a preload write and an executing instruction can land on the same edge. The bench provokes this in two ways. First, it issues a move that reads the very address being written in that cycle, and expects the old word, then the new word on the next move. Second, it runs an add while writing another address, and judges both effects: the sum on the output, and the written word when it is moved out afterwards.

// File: rtl/slice_pkg.sv
package slice_pkg;

    parameter int unsigned DW   = 4;
    parameter int unsigned AW   = 4;
    parameter int unsigned NREG = 4;
    parameter int unsigned OPW  = 4;

    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned IW    = NREG + AW + OPW;
    localparam int unsigned RIDX  = $clog2(NREG);

    typedef logic [DW-1:0] word_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_SHL  = 4'd3,
        OP_SHR  = 4'd4,
        OP_ROL  = 4'd5,
        OP_ROR  = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_NOT  = 4'd9,
        OP_MOVA = 4'd10,
        OP_MOVB = 4'd11,
        OP_MOVC = 4'd12,
        OP_MOVD = 4'd13,
        OP_NOPE = 4'd14,
        OP_NOPF = 4'd15
    } opcode_e;

    typedef struct packed {
        logic [NREG-1:0] sel;
        logic [AW-1:0]   addr;
        opcode_e         op;
    } instr_t;

    typedef struct packed {
        word_t value;
        logic  carry;
    } alu_out_t;

    typedef struct packed {
        logic [RIDX-1:0] operand_idx;
        logic [AW-1:0]   ram_addr;
        opcode_e         op;
        logic [NREG-1:0] reg_we;
        logic            is_move;
        logic            is_alu;
    } ctrl_t;

    // Lowest set bit of the one-hot select wins; an empty select picks B.
    function automatic logic [RIDX-1:0] pick_operand(input logic [NREG-1:0] sel);
        logic [RIDX-1:0] idx;
        idx = RIDX'(1);
        for (int i = NREG - 1; i >= 0; i--) begin
            if (sel[i]) idx = RIDX'(i);
        end
        return idx;
    endfunction

    function automatic logic op_is_move(input opcode_e op);
        return (op == OP_MOVA) || (op == OP_MOVB) || (op == OP_MOVC) || (op == OP_MOVD);
    endfunction

    function automatic logic op_is_alu(input opcode_e op);
        return (4'(op) <= 4'(OP_NOT));
    endfunction

endpackage

// File: rtl/slice_ram.sv
module slice_ram
    import slice_pkg::*;
#(
    parameter int unsigned W  = DW,
    parameter int unsigned A  = AW,
    localparam int unsigned N = 1 << A
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [A-1:0] waddr,
    input  logic [W-1:0] wdata,
    input  logic [A-1:0] raddr,
    output logic [W-1:0] rdata
);

    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read returns the stored word; a write on the same edge is seen next cycle.
    assign rdata = mem[raddr];

    assert_ram_write_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/slice_regfile.sv
module slice_regfile
    import slice_pkg::*;
#(
    parameter int unsigned W = DW,
    parameter int unsigned R = NREG
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [R-1:0]        we,
    input  logic                src_mem,
    input  logic [W-1:0]        mem_word,
    input  logic [W-1:0]        alu_word,
    output logic [R-1:0][W-1:0] regs
);

    logic [W-1:0] wdata;

    assign wdata = src_mem ? mem_word : alu_word;

    for (genvar g = 0; g < R; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)        regs[g] <= '0;
            else if (we[g]) regs[g] <= wdata;
        end
    end

    assert_single_write_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we));

endmodule

// File: rtl/slice_decoder.sv
module slice_decoder
    import slice_pkg::*;
(
    input  logic [IW-1:0] instr,
    output ctrl_t         ctrl
);

    instr_t            fields;
    logic [OPW-1:0]    move_off;

    assign fields   = instr_t'(instr);
    assign move_off = 4'(fields.op) - 4'(OP_MOVA);

    always_comb begin
        ctrl.operand_idx = pick_operand(fields.sel);
        ctrl.ram_addr    = fields.addr;
        ctrl.op          = fields.op;
        ctrl.is_move     = op_is_move(fields.op);
        ctrl.is_alu      = op_is_alu(fields.op);
        ctrl.reg_we      = '0;
        if (ctrl.is_move) begin
            ctrl.reg_we[move_off[RIDX-1:0]] = 1'b1;
        end else if (ctrl.is_alu && (fields.op != OP_CMP)) begin
            ctrl.reg_we[0] = 1'b1;
        end
    end

endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import slice_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  opcode_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output alu_out_t     res
);

    logic [W:0] sum_add;
    logic [W:0] sum_sub;
    logic [W:0] sum_cmp;

    assign sum_add = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    assign sum_sub = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, cin};
    assign sum_cmp = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};

    always_comb begin
        res = '0;
        case (op)
            OP_ADD: res = '{value: sum_add[W-1:0], carry: sum_add[W]};
            OP_SUB: res = '{value: sum_sub[W-1:0], carry: sum_sub[W]};
            OP_CMP: res = '{value: sum_cmp[W-1:0], carry: sum_cmp[W]};
            OP_SHL: res = '{value: {a[W-2:0], 1'b0}, carry: a[W-1]};
            OP_SHR: res = '{value: {1'b0, a[W-1:1]}, carry: a[0]};
            OP_ROL: res = '{value: {a[W-2:0], a[W-1]}, carry: a[W-1]};
            OP_ROR: res = '{value: {a[0], a[W-1:1]}, carry: a[0]};
            OP_AND: res = '{value: a & b, carry: 1'b0};
            OP_OR:  res = '{value: a | b, carry: 1'b0};
            OP_NOT: res = '{value: ~a, carry: 1'b0};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/nibble_slice_cpu.sv
module nibble_slice_cpu
    import slice_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] instr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          carry_in,
    output logic [DW-1:0] result,
    output logic          carry_out
);

    ctrl_t                    ctrl;
    word_t                    mem_word;
    logic [NREG-1:0][DW-1:0]  regs;
    word_t                    operand_b;
    alu_out_t                 alu_res;
    word_t                    result_q;
    logic                     carry_q;

    slice_decoder u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    slice_ram #(.W(DW), .A(AW)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (ctrl.ram_addr),
        .rdata (mem_word)
    );

    slice_regfile #(.W(DW), .R(NREG)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (ctrl.reg_we),
        .src_mem  (ctrl.is_move),
        .mem_word (mem_word),
        .alu_word (alu_res.value),
        .regs     (regs)
    );

    assign operand_b = regs[ctrl.operand_idx];

    slice_alu #(.W(DW)) u_alu (
        .op  (ctrl.op),
        .a   (regs[0]),
        .b   (operand_b),
        .cin (carry_in),
        .res (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            carry_q  <= 1'b0;
        end else if (ctrl.is_move) begin
            result_q <= mem_word;
            carry_q  <= 1'b0;
        end else if (ctrl.is_alu) begin
            result_q <= alu_res.value;
            carry_q  <= alu_res.carry;
        end
    end

    assign result    = result_q;
    assign carry_out = carry_q;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (result == '0) && !carry_out && (regs == '0));

    assert_move_output_R3: assert property (@(posedge clk) disable iff (rst)
        (instr[OPW-1:0] >= 4'(OP_MOVA) && instr[OPW-1:0] <= 4'(OP_MOVD))
        |=> (result == $past(mem_word)) && !carry_out);

    assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        (instr[OPW-1:0] == 4'(OP_CMP)) |=> $stable(regs));

    assert_logic_carry_R10: assert property (@(posedge clk) disable iff (rst)
        (instr[OPW-1:0] >= 4'(OP_AND) && instr[OPW-1:0] <= 4'(OP_NOT)) |=> !carry_out);

    assert_nop_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (instr[OPW-1:0] >= 4'(OP_NOPE))
        |=> $stable(result) && $stable(carry_out) && $stable(regs));

endmodule

// File: tb/test_nibble_slice_cpu.sv
module test_nibble_slice_cpu;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] instr;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [3:0]  wr_data;
    logic        carry_in;
    logic [3:0]  result;
    logic        carry_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    localparam logic [3:0] SA = 4'b0001, SB = 4'b0010, SC = 4'b0100, SD = 4'b1000, SN = 4'b0000;

    always #2 clk = ~clk;

    nibble_slice_cpu i_nibble_slice_cpu (
        .clk       (clk),
        .rst       (rst),
        .instr     (instr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out)
    );

    function automatic logic [11:0] mk(input logic [3:0] sel, input logic [3:0] addr, input logic [3:0] op);
        return {sel, addr, op};
    endfunction

    task automatic check(input string req, input logic [3:0] er, input logic ec);
        n_checks++;
        if (result !== er || carry_out !== ec) begin
            n_fails++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     req, result, carry_out, er, ec);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic step(input logic [11:0] i, input logic cin,
                        input logic we, input logic [3:0] wa, input logic [3:0] wd);
        instr    = i;
        carry_in = cin;
        wr_en    = we;
        wr_addr  = wa;
        wr_data  = wd;
        @(negedge clk);
        wr_en = 1'b0;
        instr = mk(SN, 4'h0, 4'd14);
    endtask

    task automatic op(input logic [3:0] sel, input logic [3:0] code, input logic cin,
                      input string req, input logic [3:0] er, input logic ec);
        step(mk(sel, 4'h0, code), cin, 1'b0, 4'h0, 4'h0);
        check(req, er, ec);
    endtask

    task automatic mova(input logic [3:0] addr, input logic [3:0] er);
        step(mk(SN, addr, 4'd10), 1'b0, 1'b0, 4'h0, 4'h0);
        check("R3", er, 1'b0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(mk(SN, 4'h0, 4'd14), 1'b0, 1'b0, 4'h0, 4'h0);
        step(mk(SN, 4'h0, 4'd14), 1'b0, 1'b0, 4'h0, 4'h0);
        check("R1", 4'h0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_preload;
        logic [3:0] words [8] = '{4'h5, 4'h7, 4'h3, 4'h9, 4'hF, 4'h0, 4'hA, 4'h1};
        for (int k = 0; k < 8; k++) step(mk(SN, 4'h0, 4'd14), 1'b0, 1'b1, 4'(k), words[k]);
        check("R2 preload leaves outputs", 4'h0, 1'b0);
    endtask

    task automatic t_moves;
        step(mk(SN, 4'h1, 4'd11), 1'b0, 1'b0, 4'h0, 4'h0); check("R3 MOVB", 4'h7, 1'b0);
        step(mk(SN, 4'h2, 4'd12), 1'b0, 1'b0, 4'h0, 4'h0); check("R3 MOVC", 4'h3, 1'b0);
        step(mk(SN, 4'h3, 4'd13), 1'b0, 1'b0, 4'h0, 4'h0); check("R3 MOVD", 4'h9, 1'b0);
        mova(4'h0, 4'h5);
    endtask

    task automatic t_add;
        instr    = mk(SB, 4'h0, 4'd0);
        carry_in = 1'b1;
        #1 check("R13 no change before edge", 4'h5, 1'b0);
        @(negedge clk);
        check("R5 add with carry-in", 4'hD, 1'b0);
        mova(4'h4, 4'hF);
        op(SD, 4'd0, 1'b0, "R5 add carry out", 4'h8, 1'b1);
        op(SN, 4'd8, 1'b0, "R11 R4 sum written to A, empty select is B", 4'hF, 1'b0);
    endtask

    task automatic t_sub;
        mova(4'h0, 4'h5);
        op(SC, 4'd1, 1'b1, "R6 sub no borrow", 4'h2, 1'b1);
        mova(4'h2, 4'h3);
        op(SB, 4'd1, 1'b1, "R6 sub borrow", 4'hC, 1'b0);
        mova(4'h0, 4'h5);
        op(SC, 4'd1, 1'b0, "R6 sub with borrow-in", 4'h1, 1'b1);
    endtask

    task automatic t_cmp;
        mova(4'h1, 4'h7);
        op(SB, 4'd2, 1'b0, "R7 cmp equal", 4'h0, 1'b1);
        op(SA, 4'd8, 1'b0, "R7 A unchanged after cmp", 4'h7, 1'b0);
        mova(4'h2, 4'h3);
        op(SB, 4'd2, 1'b0, "R7 cmp less, carry-in ignored", 4'hC, 1'b0);
        op(SA, 4'd8, 1'b0, "R7 A unchanged after cmp", 4'h3, 1'b0);
    endtask

    task automatic t_select;
        mova(4'h5, 4'h0);
        op(4'b0110, 4'd8, 1'b0, "R4 lowest select bit wins", 4'h7, 1'b0);
        mova(4'h5, 4'h0);
        op(SD, 4'd8, 1'b0, "R4 select D", 4'h9, 1'b0);
        mova(4'h5, 4'h0);
        op(SC, 4'd8, 1'b0, "R4 select C", 4'h3, 1'b0);
        mova(4'h5, 4'h0);
        op(4'b1111, 4'd8, 1'b0, "R4 all bits set picks A", 4'h0, 1'b0);
    endtask

    task automatic t_shift;
        mova(4'h3, 4'h9);
        op(SN, 4'd3, 1'b0, "R8 shl", 4'h2, 1'b1);
        op(SN, 4'd4, 1'b0, "R8 shr", 4'h1, 1'b0);
        op(SN, 4'd4, 1'b0, "R8 shr out", 4'h0, 1'b1);
    endtask

    task automatic t_rotate;
        mova(4'h3, 4'h9);
        op(SN, 4'd5, 1'b0, "R9 rol", 4'h3, 1'b1);
        mova(4'h3, 4'h9);
        op(SN, 4'd6, 1'b0, "R9 ror", 4'hC, 1'b1);
        mova(4'h6, 4'hA);
        op(SN, 4'd6, 1'b0, "R9 ror zero wrap", 4'h5, 1'b0);
        op(SN, 4'd5, 1'b0, "R9 rol zero wrap", 4'hA, 1'b0);
    endtask

    task automatic t_logic;
        mova(4'h3, 4'h9);
        op(SN, 4'd3, 1'b0, "R8 shl set carry", 4'h2, 1'b1);
        op(SB, 4'd7, 1'b1, "R10 and clears carry", 4'h2, 1'b0);
        mova(4'h4, 4'hF);
        op(SD, 4'd7, 1'b0, "R10 and", 4'h9, 1'b0);
        mova(4'h6, 4'hA);
        op(SN, 4'd9, 1'b0, "R10 not", 4'h5, 1'b0);
    endtask

    task automatic t_nop;
        mova(4'h3, 4'h9);
        op(SN, 4'd5, 1'b0, "R9 rol", 4'h3, 1'b1);
        op(SN, 4'd14, 1'b1, "R12 opcode 14 holds", 4'h3, 1'b1);
        step(mk(4'b1111, 4'h4, 4'd15), 1'b1, 1'b0, 4'h0, 4'h0);
        check("R12 opcode 15 holds", 4'h3, 1'b1);
        op(SA, 4'd8, 1'b0, "R12 A untouched by nop", 4'h3, 1'b0);
    endtask

    task automatic t_collide;
        step(mk(SN, 4'h7, 4'd10), 1'b0, 1'b1, 4'h7, 4'hE);
        check("R14 move sees old word", 4'h1, 1'b0);
        mova(4'h7, 4'hE);
        mova(4'h0, 4'h5);
        step(mk(SB, 4'h0, 4'd0), 1'b0, 1'b1, 4'h5, 4'h6);
        check("R14 add beside write", 4'hC, 1'b0);
        mova(4'h5, 4'h6);
    endtask

    task automatic t_midreset;
        rst = 1'b1;
        step(mk(SN, 4'h1, 4'd11), 1'b0, 1'b0, 4'h0, 4'h0);
        check("R1 reset beats move", 4'h0, 1'b0);
        rst = 1'b0;
        op(SB, 4'd8, 1'b0, "R1 A and B cleared", 4'h0, 1'b0);
        op(SD, 4'd0, 1'b1, "R1 D cleared", 4'h1, 1'b0);
    endtask

    initial begin
        rst      = 1'b1;
        instr    = mk(SN, 4'h0, 4'd14);
        wr_en    = 1'b0;
        wr_addr  = '0;
        wr_data  = '0;
        carry_in = 1'b0;
        @(negedge clk);
        t_reset;
        t_preload;
        t_moves;
        t_add;
        t_sub;
        t_cmp;
        t_select;
        t_shift;
        t_rotate;
        t_logic;
        t_nop;
        t_collide;
        t_midreset;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule